// File: doc/BRIEF.md
# Byte-Memory DMA Engine

This block moves blocks of data between an external memory that is eight bits wide and an on-chip memory made of wider words. It runs in the background while the processor keeps executing. Software sets up a byte address, a word address, a direction and a wait-state count. It then writes a nonzero word count, and that write launches the transfer.

When moving data inward, the engine reads consecutive bytes and assembles each internal word with the most significant byte first. When moving data outward, it reads a word from on-chip memory and emits its bytes most significant first. Every external byte access holds its strobe for one cycle plus the programmed number of wait states. The remaining count falls by one after each whole word. When the count reaches zero, the engine raises a single-cycle interrupt request.

If zero is written while a transfer is running, the transfer stops cleanly once the current word is complete.

Top module: `bytemem_dma`

## Requirements
- R1: After reset the engine is idle: `busy` low, `count` zero, `done` low, and no strobe asserted on either memory.
- R2: Writing a nonzero value to the count while idle starts a transfer on the next clock, using the configuration present on that write. Writing zero while idle has no effect: no strobe, no `busy`, no `done`.
- R3: Every external byte access keeps `bm_rd` or `bm_wr` asserted for exactly `cfg_wait`+1 consecutive cycles with a stable address. `cfg_wait` is 3 bits, 0 to 7.
- R4: The first byte access uses `cfg_baddr`. Each later access uses the previous address plus one, wrapping modulo 2^22.
- R5: Direction 0 (`cfg_to_byte`=0, byte to word): each group of consecutive bytes is packed with the first byte in bits [15:8]. The word is written with one `im_we` cycle, at `cfg_waddr` for the first word and then at increasing consecutive word addresses.
- R6: Direction 1 (word to byte): each word is read with one `im_re` cycle, its data being valid on the following cycle. Bits [15:8] go out on the first byte access and bits [7:0] on the second.
- R7: `count` falls by one after each complete word. The transfer moves exactly the programmed number of words. `busy` lasts 2*(`cfg_wait`+1)+1 cycles per word in direction 0 and 2*(`cfg_wait`+1)+2 cycles per word in direction 1.
- R8: When the last word completes, `done` pulses high for exactly one cycle. In that cycle `busy` is low and `count` is zero.
- R9: Writing zero to the count during a transfer lets the word in progress complete, then ends the transfer with `count` at zero and a `done` pulse.
- R10: Writing a nonzero value to the count during a transfer is ignored. The transfer still moves the originally programmed number of words.
- R11: `bm_rd` and `bm_wr` are never asserted together, and no memory strobe is asserted while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_we | input | 1 | Write strobe for the word count |
| cnt_wdata | input | CNT_W | Word count value written |
| cfg_baddr | input | BADDR_W | Starting external byte address |
| cfg_waddr | input | WADDR_W | Starting internal word address |
| cfg_to_byte | input | 1 | 0: byte memory to words, 1: words to byte memory |
| cfg_wait | input | WAIT_W | Wait states added to each byte access |
| busy | output | 1 | Transfer in progress |
| count | output | CNT_W | Words remaining |
| done | output | 1 | One-cycle completion interrupt request |
| bm_addr | output | BADDR_W | External byte address |
| bm_rd | output | 1 | External read strobe |
| bm_wr | output | 1 | External write strobe |
| bm_wdata | output | 8 | External write data |
| bm_rdata | input | 8 | External read data, sampled in the last cycle of an access |
| im_addr | output | WADDR_W | Internal word address |
| im_re | output | 1 | Internal read strobe, data expected one cycle later |
| im_we | output | 1 | Internal write strobe |
| im_wdata | output | WORD_W | Internal write data |
| im_rdata | input | WORD_W | Internal read data |

## Verification
The checker enforces the strobe rules on every cycle: read and write never overlap, and nothing is driven while idle. It also checks that no access outlasts its wait-state budget, that the byte address only steps by one, that the count never rises during a transfer, and that the completion pulse is single and arrives with the engine idle and the count at zero. Other properties can only be shown by the directed scenarios: the byte order inside each word, the exact number of words and cycles, the address wrap at the top of the 4 MByte space, and the outcome of count writes made in the middle of a transfer.

// File: rtl/bdma_pkg.sv
// Shared types for the byte-memory DMA engine.
package bdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a nonzero count write
        ST_IRD,    // issue an internal word read
        ST_ILAT,   // capture the internal read data
        ST_XACC,   // external byte access, possibly stretched
        ST_IWR     // write the packed word to internal memory
    } bdma_state_t;
endpackage

// File: rtl/bdma_waitgen.sv
// Wait-state generator. Assumes 'active' stays high for the whole of an
// external access. 'access_end' marks the final cycle of each access,
// which comes wait_ld cycles after the first one.
module bdma_waitgen #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [WAIT_W-1:0] wait_ld,
    output logic              access_end
);
    logic [WAIT_W-1:0] wcnt;

    assign access_end = active && (wcnt == wait_ld);

    // count the cycles already spent in the current access
    always_ff @(posedge clk) begin
        if (!rst_n)                    wcnt <= '0;
        else if (!active || access_end) wcnt <= '0;
        else                           wcnt <= wcnt + 1'b1;
    end
endmodule

// File: rtl/bdma_packer.sv
// Byte/word shift register. Assumes WORD_W is a multiple of 8 and at least 16.
// The most significant byte leaves first and arrives first; new bytes
// enter at the bottom of the register.
module bdma_packer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic [7:0]        fill_byte,
    output logic [WORD_W-1:0] word,
    output logic [7:0]        byte_out,
    output logic              last_byte
);
    localparam int NB    = WORD_W / 8;
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  bidx;

    assign word      = shreg;
    assign byte_out  = shreg[WORD_W-1 -: 8];
    assign last_byte = (bidx == LAST_IDX);

    // hold, load or shift the data bytes
    always_ff @(posedge clk) begin
        if (!rst_n)     shreg <= '0;
        else if (load)  shreg <= load_word;
        else if (shift) shreg <= {shreg[WORD_W-9:0], fill_byte};
    end

    // position of the current byte within the word
    always_ff @(posedge clk) begin
        if (!rst_n || clear) bidx <= '0;
        else if (shift)      bidx <= last_byte ? '0 : bidx + 1'b1;
    end
endmodule

// File: rtl/bdma_ctrl.sv
// Transfer sequencer: state machine, address and count registers, and
// the completion pulse. Assumes internal memory accepts a request in
// every cycle and returns read data on the cycle after im_re.
module bdma_ctrl
    import bdma_pkg::*;
#(
    parameter int BADDR_W = 22,
    parameter int WADDR_W = 14,
    parameter int CNT_W   = 14,
    parameter int WAIT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_we,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic [BADDR_W-1:0] cfg_baddr,
    input  logic [WADDR_W-1:0] cfg_waddr,
    input  logic               cfg_to_byte,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic               access_end,
    input  logic               last_byte,
    output logic               xacc,
    output logic [WAIT_W-1:0]  wait_q,
    output logic               dir_q,
    output logic               start,
    output logic               pk_load,
    output logic               pk_shift,
    output logic               busy,
    output logic [CNT_W-1:0]   count,
    output logic               done,
    output logic [BADDR_W-1:0] bm_addr,
    output logic               bm_rd,
    output logic               bm_wr,
    output logic [WADDR_W-1:0] im_addr,
    output logic               im_re,
    output logic               im_we
);
    bdma_state_t        state, nxt;
    logic [BADDR_W-1:0] baddr;
    logic [WADDR_W-1:0] waddr;
    logic [CNT_W-1:0]   cnt;
    logic               stop_req;
    logic               stop_now;
    logic               word_end;
    logic               last_word;

    assign busy      = (state != ST_IDLE);
    assign start     = !busy && cnt_we && (cnt_wdata != '0);
    assign stop_now  = stop_req || (busy && cnt_we && (cnt_wdata == '0));
    assign xacc      = (state == ST_XACC);
    assign pk_shift  = xacc && access_end;
    assign pk_load   = (state == ST_ILAT);
    assign word_end  = (state == ST_IWR) || (pk_shift && last_byte && dir_q);
    assign last_word = (cnt == CNT_W'(1)) || stop_now;

    assign count   = cnt;
    assign bm_addr = baddr;
    assign bm_rd   = xacc && !dir_q;
    assign bm_wr   = xacc && dir_q;
    assign im_addr = waddr;
    assign im_re   = (state == ST_IRD);
    assign im_we   = (state == ST_IWR);

    // choose the next state of the transfer
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = cfg_to_byte ? ST_IRD : ST_XACC;
            ST_IRD:  nxt = ST_ILAT;
            ST_ILAT: nxt = ST_XACC;
            ST_XACC: if (access_end && last_byte)
                         nxt = !dir_q ? ST_IWR : (last_word ? ST_IDLE : ST_IRD);
            ST_IWR:  nxt = last_word ? ST_IDLE : ST_XACC;
            default: nxt = ST_IDLE;
        endcase
    end

    // state, configuration capture, address and count updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            baddr    <= '0;
            waddr    <= '0;
            cnt      <= '0;
            dir_q    <= 1'b0;
            wait_q   <= '0;
            stop_req <= 1'b0;
            done     <= 1'b0;
        end else begin
            state <= nxt;
            done  <= word_end && last_word;
            if (start) begin
                baddr    <= cfg_baddr;
                waddr    <= cfg_waddr;
                cnt      <= cnt_wdata;
                dir_q    <= cfg_to_byte;
                wait_q   <= cfg_wait;
                stop_req <= 1'b0;
            end else begin
                if (busy && cnt_we && (cnt_wdata == '0)) stop_req <= 1'b1;
                if (pk_shift) baddr <= baddr + 1'b1;
                if (word_end) begin
                    waddr <= waddr + 1'b1;
                    cnt   <= last_word ? '0 : cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bytemem_dma.sv
// Top of the byte-memory DMA engine. It joins the sequencer, the
// wait-state generator and the byte packer. Assumes WORD_W is a
// multiple of 8 and that neither memory ever stalls the engine.
module bytemem_dma #(
    parameter int BADDR_W = 22,
    parameter int WADDR_W = 14,
    parameter int WORD_W  = 16,
    parameter int CNT_W   = 14,
    parameter int WAIT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_we,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic [BADDR_W-1:0] cfg_baddr,
    input  logic [WADDR_W-1:0] cfg_waddr,
    input  logic               cfg_to_byte,
    input  logic [WAIT_W-1:0]  cfg_wait,
    output logic               busy,
    output logic [CNT_W-1:0]   count,
    output logic               done,
    output logic [BADDR_W-1:0] bm_addr,
    output logic               bm_rd,
    output logic               bm_wr,
    output logic [7:0]         bm_wdata,
    input  logic [7:0]         bm_rdata,
    output logic [WADDR_W-1:0] im_addr,
    output logic               im_re,
    output logic               im_we,
    output logic [WORD_W-1:0]  im_wdata,
    input  logic [WORD_W-1:0]  im_rdata
);
    logic              xacc, access_end, last_byte, dir_q, start;
    logic              pk_load, pk_shift;
    logic [WAIT_W-1:0] wait_q;
    logic [7:0]        fill_byte;

    // inward transfers shift in read bytes; outward ones shift in zeros
    assign fill_byte = dir_q ? 8'h00 : bm_rdata;

    bdma_ctrl #(
        .BADDR_W(BADDR_W), .WADDR_W(WADDR_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cfg_baddr(cfg_baddr), .cfg_waddr(cfg_waddr),
        .cfg_to_byte(cfg_to_byte), .cfg_wait(cfg_wait),
        .access_end(access_end), .last_byte(last_byte),
        .xacc(xacc), .wait_q(wait_q), .dir_q(dir_q), .start(start),
        .pk_load(pk_load), .pk_shift(pk_shift),
        .busy(busy), .count(count), .done(done),
        .bm_addr(bm_addr), .bm_rd(bm_rd), .bm_wr(bm_wr),
        .im_addr(im_addr), .im_re(im_re), .im_we(im_we)
    );

    bdma_waitgen #(.WAIT_W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n),
        .active(xacc), .wait_ld(wait_q), .access_end(access_end)
    );

    bdma_packer #(.WORD_W(WORD_W)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .clear(start), .load(pk_load), .load_word(im_rdata),
        .shift(pk_shift), .fill_byte(fill_byte),
        .word(im_wdata), .byte_out(bm_wdata), .last_byte(last_byte)
    );
endmodule

// File: rtl/bdma_checker.sv
// Protocol checker for bytemem_dma, attached to it through bind. It watches
// the ports only and keeps its own record of the current access.
module bdma_checker #(
    parameter int BADDR_W = 22,
    parameter int CNT_W   = 14,
    parameter int WAIT_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic [CNT_W-1:0]   count,
    input logic [BADDR_W-1:0] bm_addr,
    input logic               bm_rd,
    input logic               bm_wr,
    input logic               im_re,
    input logic               im_we,
    input logic               cnt_we,
    input logic [CNT_W-1:0]   cnt_wdata,
    input logic [WAIT_W-1:0]  cfg_wait
);
    logic               strobe, prev_strobe;
    logic [BADDR_W-1:0] prev_addr;
    logic [7:0]         run_q, cur_run;
    logic [WAIT_W-1:0]  exp_wait;

    assign strobe  = bm_rd || bm_wr;
    assign cur_run = (strobe && prev_strobe && bm_addr == prev_addr) ? run_q + 8'd1 : 8'd0;

    // remember the previous access and the wait setting of this transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_strobe <= 1'b0;
            prev_addr   <= '0;
            run_q       <= '0;
            exp_wait    <= '0;
        end else begin
            prev_strobe <= strobe;
            prev_addr   <= bm_addr;
            run_q       <= cur_run;
            if (!busy && cnt_we && cnt_wdata != '0) exp_wait <= cfg_wait;
        end
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bm_rd && bm_wr));                                              // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bm_rd || bm_wr || im_re || im_we));                  // R11
    AST_WAIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> cur_run <= 8'(exp_wait));                             // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && prev_strobe && bm_addr != prev_addr)
            |-> bm_addr == BADDR_W'(prev_addr + 1'b1));                  // R4
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> count <= $past(count));                // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && count == '0));                                // R8
endmodule

bind bytemem_dma bdma_checker #(
    .BADDR_W(BADDR_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)
) u_bdma_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .count(count),
    .bm_addr(bm_addr), .bm_rd(bm_rd), .bm_wr(bm_wr),
    .im_re(im_re), .im_we(im_we),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cfg_wait(cfg_wait)
);

// File: tb/test_bytemem_dma.sv
module test_bytemem_dma;
    localparam int CLK_PERIOD = 10;
    localparam int BADDR_W = 22;
    localparam int WADDR_W = 14;
    localparam int WORD_W  = 16;
    localparam int CNT_W   = 14;
    localparam int WAIT_W  = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cnt_we = 1'b0;
    logic [CNT_W-1:0]   cnt_wdata = '0;
    logic [BADDR_W-1:0] cfg_baddr = '0;
    logic [WADDR_W-1:0] cfg_waddr = '0;
    logic               cfg_to_byte = 1'b0;
    logic [WAIT_W-1:0]  cfg_wait = '0;
    logic               busy, done, bm_rd, bm_wr, im_re, im_we;
    logic [CNT_W-1:0]   count;
    logic [BADDR_W-1:0] bm_addr;
    logic [7:0]         bm_wdata, bm_rdata;
    logic [WADDR_W-1:0] im_addr;
    logic [WORD_W-1:0]  im_wdata;
    logic [WORD_W-1:0]  im_rdata = '0;

    logic [7:0]  bmem [256];
    logic [15:0] imem [64];

    int total = 0, bad = 0;
    int done_cnt = 0, words_wr = 0, busy_cycles = 0, acc_cnt = 0;
    int run = 0, exp_wait = 0;
    logic               prev_strobe = 1'b0, prev_done = 1'b0;
    logic [BADDR_W-1:0] prev_addr = '0, exp_baddr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytemem_dma #(
        .BADDR_W(BADDR_W), .WADDR_W(WADDR_W), .WORD_W(WORD_W),
        .CNT_W(CNT_W), .WAIT_W(WAIT_W)
    ) i_bytemem_dma (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cfg_baddr(cfg_baddr), .cfg_waddr(cfg_waddr),
        .cfg_to_byte(cfg_to_byte), .cfg_wait(cfg_wait),
        .busy(busy), .count(count), .done(done),
        .bm_addr(bm_addr), .bm_rd(bm_rd), .bm_wr(bm_wr),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata),
        .im_addr(im_addr), .im_re(im_re), .im_we(im_we),
        .im_wdata(im_wdata), .im_rdata(im_rdata)
    );

    // memory models
    assign bm_rdata = bmem[bm_addr[7:0]];
    always @(posedge clk) begin
        if (bm_wr) bmem[bm_addr[7:0]] <= bm_wdata;
        if (im_we) imem[im_addr[5:0]] <= im_wdata;
        if (im_re) im_rdata <= imem[im_addr[5:0]];
    end

    function automatic logic [7:0] bpat(input logic [BADDR_W-1:0] a);
        return 8'(a[7:0] * 37 + 5);
    endfunction
    function automatic logic [15:0] wpat(input int a);
        return 16'(16'hA000 + (a % 64) * 263);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill_mems();
        for (int i = 0; i < 256; i++) bmem[i] = bpat(BADDR_W'(i));
        for (int i = 0; i < 64; i++) imem[i] = wpat(i);
    endtask

    // port monitor: access length, address sequence, done pulses, counters
    always @(negedge clk) begin
        if (rst_n) begin
            if ((bm_rd || bm_wr) && prev_strobe && bm_addr == prev_addr) run++;
            else begin
                if (prev_strobe) chk("R3", "access length", run, exp_wait + 1);
                if (bm_rd || bm_wr) begin
                    chk("R4", "byte address", bm_addr, exp_baddr);
                    exp_baddr = exp_baddr + 1'b1;
                    acc_cnt++;
                    run = 1;
                end
            end
            if (bm_rd && bm_wr) chk("R11", "rd and wr together", 1, 0);
            prev_strobe = bm_rd || bm_wr;
            prev_addr   = bm_addr;
            if (done) begin
                done_cnt++;
                if (prev_done) chk("R8", "done width", 2, 1);
            end
            prev_done = done;
            if (im_we) words_wr++;
            if (busy) busy_cycles++;
        end
    end

    task automatic kick(input logic dir, input logic [BADDR_W-1:0] ba,
                        input int wa, input int n, input int w);
        @(negedge clk);
        cfg_to_byte = dir; cfg_baddr = ba; cfg_waddr = WADDR_W'(wa);
        cfg_wait = WAIT_W'(w); cnt_wdata = CNT_W'(n); cnt_we = 1'b1;
        exp_baddr = ba; exp_wait = w;
        done_cnt = 0; words_wr = 0; busy_cycles = 0; acc_cnt = 0;
        @(negedge clk);
        cnt_we = 1'b0;
        cfg_baddr = '0; cfg_waddr = '0; cfg_wait = '0;
    endtask

    task automatic write_count(input int v);
        cnt_wdata = CNT_W'(v); cnt_we = 1'b1;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (done_cnt == 0 && guard < 3000) begin @(negedge clk); guard++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "count", count, 0);
        chk("R1", "done", done, 0);
        chk("R1", "strobes", {bm_rd, bm_wr, im_re, im_we}, 0);
    endtask

    task automatic t_idle_zero();
        kick(1'b0, 22'h000040, 0, 0, 2);
        repeat (10) @(negedge clk);
        chk("R2", "busy cycles after zero write", busy_cycles, 0);
        chk("R2", "accesses after zero write", acc_cnt, 0);
        chk("R2", "done after zero write", done_cnt, 0);
        chk("R11", "internal writes while idle", words_wr, 0);
    endtask

    task automatic t_inward(input logic [BADDR_W-1:0] ba, input int wa, input int n, input int w);
        fill_mems();
        kick(1'b0, ba, wa, n, w);
        wait_done();
        for (int k = 0; k < n; k++) begin
            logic [BADDR_W-1:0] a0 = ba + BADDR_W'(2 * k);
            chk("R5", "packed word", imem[(wa + k) % 64], {bpat(a0), bpat(a0 + 1'b1)});
        end
        chk("R7", "words written", words_wr, n);
        chk("R7", "busy cycles inward", busy_cycles, n * (2 * (w + 1) + 1));
        chk("R4", "access count", acc_cnt, 2 * n);
        chk("R8", "done pulses", done_cnt, 1);
        chk("R8", "final count", count, 0);
    endtask

    task automatic t_outward(input logic [BADDR_W-1:0] ba, input int wa, input int n, input int w);
        fill_mems();
        kick(1'b1, ba, wa, n, w);
        wait_done();
        for (int k = 0; k < n; k++) begin
            logic [BADDR_W-1:0] a0 = ba + BADDR_W'(2 * k);
            logic [15:0] src = wpat(wa + k);
            chk("R6", "high byte", bmem[a0[7:0]], src[15:8]);
            chk("R6", "low byte", bmem[8'(a0[7:0] + 1)], src[7:0]);
        end
        chk("R7", "busy cycles outward", busy_cycles, n * (2 * (w + 1) + 2));
        chk("R4", "access count", acc_cnt, 2 * n);
        chk("R8", "done pulses", done_cnt, 1);
        chk("R8", "final count", count, 0);
    endtask

    task automatic t_stop_mid();
        fill_mems();
        kick(1'b0, 22'h000080, 20, 5, 2);
        repeat (9) @(negedge clk);
        chk("R7", "count after one word", count, 4);
        write_count(0);
        wait_done();
        chk("R9", "words before stop", words_wr, 2);
        chk("R9", "busy cycles with stop", busy_cycles, 14);
        chk("R9", "count after stop", count, 0);
        chk("R9", "done after stop", done_cnt, 1);
        chk("R9", "second word", imem[21], {bpat(22'h000082), bpat(22'h000083)});
    endtask

    task automatic t_busy_nonzero();
        fill_mems();
        kick(1'b0, 22'h0000A0, 30, 3, 0);
        repeat (2) @(negedge clk);
        write_count(9);
        wait_done();
        chk("R10", "words despite rewrite", words_wr, 3);
        chk("R10", "busy cycles despite rewrite", busy_cycles, 9);
        chk("R10", "done pulses", done_cnt, 1);
        chk("R10", "final count", count, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        fill_mems();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_zero();
        t_inward(22'h000010, 4, 1, 0);
        t_inward(22'h000020, 8, 3, 7);
        t_inward(22'h3FFFFF, 12, 1, 1);       // R4 wrap at top of space
        t_outward(22'h000030, 2, 2, 0);
        t_outward(22'h000050, 40, 3, 5);
        t_stop_mid();
        t_busy_nonzero();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule